// File: doc/BRIEF.md
# ATM Header Check and Single-Bit Repair Stage

This stage sits in a receive cell path. Cells arrive one byte per transfer on a valid/ready stream, 53 bytes per cell, and the first byte carries a start marker. The stage holds the first five bytes, which are the four header bytes and the check byte. It computes a CRC-8 over the four header bytes and compares the result with the check byte. It then replays the cell downstream with two per-cell flags: one marks the cell for discard and one reports that a header bit was repaired.

A two-mode machine decides what happens to a cell that fails the check. In repair mode, a single-bit error anywhere in the five header bytes is corrected. A multi-bit error marks the cell for discard. Either kind of error moves the machine to screening mode. In screening mode, every failing cell is marked for discard and left unmodified. The machine goes back to repair mode only after a programmable run of cells that pass the check. A configuration bit can hold the machine in screening mode for good, and an override bit clears the discard flag on errored cells. Two saturating counters record repaired cells and discard-flagged cells.

On the input side, the stage accepts bytes freely while it collects a header (`in_ready` high). While the five held header bytes are replayed, `in_ready` is low. For the 48 payload bytes the stage is a wire: `out_valid` follows `in_valid`, `in_ready` follows `out_ready`, and a byte moves only when valid and ready are both high. A source must keep `in_valid` and `in_data` steady until the byte is taken. The sink may stall at any cycle.

Top module: `atm_hec_guard`

## Requirements
- R1: The check byte is expected to equal CRC-8 of header bytes 1..4 XOR 0x55. The CRC uses polynomial x^8+x^2+x+1 (0x07), zero initial value, and processes byte 1 first, MSB first. A cell that passes is output unchanged with both flags 0.
- R2: After reset, `out_valid` is 0, `in_ready` is 1, both counters are 0, the machine is in repair mode and the good-cell run is 0.
- R3: In repair mode (with `cfg_corr_en`=1), a single-bit error in any of the 40 header bits, including the check byte, is corrected. The cell is output with the repaired header, `out_corrected`=1 and `out_discard`=0. The machine then enters screening mode.
- R4: In repair mode, a multi-bit error gives `out_discard`=1 (unless R6 applies), leaves the header as received, and moves the machine to screening mode.
- R5: In screening mode, every cell that fails the check gets `out_discard`=1 (unless R6 applies), is output unmodified, and resets the good-cell run to 0.
- R6: With `cfg_err_ignore`=1, errored cells that are not repaired get `out_discard`=0, are output unmodified and are not counted.
- R7: `cfg_thresh` selects the run length M: 0→0, 1→1, 2→3, 3→7. In screening mode, the cell that passes the check when M passing cells have already been seen in a row is itself handled under screening rules, and then the machine returns to repair mode. The next cell is handled under repair rules.
- R8: With `cfg_corr_en`=0, the machine never enters repair mode. If the bit is cleared while in repair mode, the next cell is handled under screening rules.
- R9: `cnt_corrected` counts cells with `out_corrected`=1 and `cnt_discarded` counts cells with `out_discard`=1. Each saturates at 2^CNT_W-1.
- R10: `out_discard` and `out_corrected` are valid with the first output byte of a cell and stay unchanged through all 53 output bytes of that cell.
- R11: No byte of a cell is output before its five header bytes are taken. Each cell leaves as 53 bytes with `out_sop` on the first byte only. `in_ready` is 0 while the header is replayed and equals `out_ready` during the payload.
- R12: A byte with `in_sop`=1 taken during header collection restarts collection, so the bytes collected before it are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_corr_en | input | 1 | 1 allows repair mode, 0 keeps screening mode |
| cfg_thresh | input | 2 | Run-length select M (0,1,3,7) |
| cfg_err_ignore | input | 1 | 1 clears the discard flag on errored cells |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Stage can take the input byte |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Input byte is the first byte of a cell |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink takes the output byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Output byte is the first byte of a cell |
| out_discard | output | 1 | Current cell marked for discard |
| out_corrected | output | 1 | Current cell had a header bit repaired |
| cnt_corrected | output | CNT_W | Saturating count of repaired cells |
| cnt_discarded | output | CNT_W | Saturating count of discard-flagged cells |

## Verification
The assertions assume a well-formed source stream. The start marker sits on the first byte of each 53-byte cell, and `in_valid` with its data stays asserted until the byte is taken. The flag-stability property also relies on the configuration inputs not changing while a cell's header is being judged. The bench drives whole cells from a table of headers and keeps a pending byte on the bus until it is taken, whatever the stall pattern. It changes configuration only between cells. The one deliberate break from well-formed framing is a truncated header followed by a fresh start marker.

// File: rtl/atm_hec_pkg.sv
`timescale 1ns/1ps
package atm_hec_pkg;

  typedef enum logic {
    ST_CORR = 1'b0,
    ST_DET  = 1'b1
  } hec_mode_e;

  typedef enum logic [1:0] {
    PH_COLLECT = 2'd0,
    PH_REPLAY  = 2'd1,
    PH_BODY    = 2'd2
  } cell_phase_e;

  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam int         HDR_BITS  = 40;

  // CRC-8 over 32 header bits, first byte in bits 31:24, MSB first.
  function automatic logic [7:0] crc8_hdr(input logic [31:0] d);
    logic [7:0] r;
    logic       fb;
    r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0} ^ (fb ? HEC_POLY : 8'h00);
    end
    return r;
  endfunction

  // Syndrome produced by a lone error at word bit p (0 = LSB of check byte).
  function automatic logic [7:0] pos_syndrome(input int p);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 0; i < HDR_BITS; i++) begin
      if (i < p) r = {r[6:0], 1'b0} ^ (r[7] ? HEC_POLY : 8'h00);
    end
    return r;
  endfunction

endpackage

// File: rtl/atm_hec_syndrome.sv
`timescale 1ns/1ps
module atm_hec_syndrome
  import atm_hec_pkg::*;
(
  input  logic [HDR_BITS-1:0] word,
  output logic                syn_zero,
  output logic                syn_single,
  output logic [HDR_BITS-1:0] fix_mask
);
  logic [7:0] syndrome;

  always_comb begin
    syndrome = crc8_hdr(word[HDR_BITS-1:8]) ^ HEC_COSET ^ word[7:0];
    for (int p = 0; p < HDR_BITS; p++) begin
      fix_mask[p] = (syndrome == pos_syndrome(p));
    end
    syn_zero   = (syndrome == 8'h00);
    syn_single = |fix_mask;
  end

endmodule

// File: rtl/atm_hec_mode_fsm.sv
`timescale 1ns/1ps
module atm_hec_mode_fsm
  import atm_hec_pkg::*;
#(
  parameter int RUN_W = 3
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      verdict,
  input  logic      syn_zero,
  input  logic      syn_single,
  input  logic      cfg_corr_en,
  input  logic [1:0] cfg_thresh,
  input  logic      cfg_err_ignore,
  output logic      mark_discard,
  output logic      mark_corrected
);
  hec_mode_e        mode_q;
  logic [RUN_W-1:0] run_q;
  logic [RUN_W-1:0] m_lim;
  logic             act_corr;

  always_comb begin
    m_lim          = RUN_W'((4'd1 << cfg_thresh) - 4'd1);
    act_corr       = (mode_q == ST_CORR) && cfg_corr_en;
    mark_corrected = act_corr && !syn_zero && syn_single;
    mark_discard   = !syn_zero && !cfg_err_ignore && !mark_corrected;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= ST_CORR;
      run_q  <= '0;
    end else if (verdict) begin
      if (act_corr) begin
        if (!syn_zero) begin
          mode_q <= ST_DET;
          run_q  <= '0;
        end
      end else if (!syn_zero) begin
        mode_q <= ST_DET;
        run_q  <= '0;
      end else if (cfg_corr_en && (run_q >= m_lim)) begin
        mode_q <= ST_CORR;
        run_q  <= '0;
      end else begin
        mode_q <= ST_DET;
        run_q  <= (run_q == '1) ? run_q : run_q + 1'b1;
      end
    end
  end

  assert_error_leaves_corr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict && !syn_zero) |=> (mode_q == ST_DET));

  assert_run_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict && !syn_zero) |=> (run_q == '0));

  assert_no_corr_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict && !cfg_corr_en) |=> (mode_q == ST_DET));

  assert_recover_after_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == ST_CORR && $past(mode_q) == ST_DET) |->
      ($past(verdict) && $past(syn_zero) && $past(cfg_corr_en) && ($past(run_q) >= $past(m_lim))));

endmodule

// File: rtl/atm_hec_sat_counter.sv
`timescale 1ns/1ps
module atm_hec_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else if (inc && (count != '1)) count <= count + 1'b1;
  end

  assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '1) |=> (count == '1));

endmodule

// File: rtl/atm_hec_guard.sv
`timescale 1ns/1ps
module atm_hec_guard
  import atm_hec_pkg::*;
#(
  parameter int CELL_LEN = 53,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_corr_en,
  input  logic [1:0]       cfg_thresh,
  input  logic             cfg_err_ignore,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_sop,
  output logic             out_discard,
  output logic             out_corrected,
  output logic [CNT_W-1:0] cnt_corrected,
  output logic [CNT_W-1:0] cnt_discarded
);
  localparam int HDR_LEN = HDR_BITS / 8;
  localparam int IDX_W   = $clog2(CELL_LEN);
  localparam int HIDX_W  = $clog2(HDR_LEN);

  cell_phase_e         phase_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    hdr_idx;
  logic [7:0]          hdr_q [HDR_LEN];
  logic                disc_q, corr_q;
  logic                verdict;
  logic [HDR_BITS-1:0] word, fixed, fix_mask;
  logic                syn_zero, syn_single;
  logic                mark_discard, mark_corrected;
  logic [1:0]          cnt_inc;
  logic [CNT_W-1:0]    cnt_val [2];

  always_comb begin
    hdr_idx = in_sop ? '0 : idx_q;
    verdict = (phase_q == PH_COLLECT) && in_valid && (hdr_idx == IDX_W'(HDR_LEN - 1));
    word    = {hdr_q[0], hdr_q[1], hdr_q[2], hdr_q[3], in_data};
    fixed   = mark_corrected ? (word ^ fix_mask) : word;
  end

  atm_hec_syndrome u_syn (
    .word       (word),
    .syn_zero   (syn_zero),
    .syn_single (syn_single),
    .fix_mask   (fix_mask)
  );

  atm_hec_mode_fsm #(.RUN_W(3)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .verdict        (verdict),
    .syn_zero       (syn_zero),
    .syn_single     (syn_single),
    .cfg_corr_en    (cfg_corr_en),
    .cfg_thresh     (cfg_thresh),
    .cfg_err_ignore (cfg_err_ignore),
    .mark_discard   (mark_discard),
    .mark_corrected (mark_corrected)
  );

  // Stream steering per phase
  always_comb begin
    in_ready  = 1'b0;
    out_valid = 1'b0;
    out_data  = 8'h00;
    out_sop   = 1'b0;
    unique case (phase_q)
      PH_COLLECT: in_ready = 1'b1;
      PH_REPLAY: begin
        out_valid = 1'b1;
        out_data  = hdr_q[idx_q[HIDX_W-1:0]];
        out_sop   = (idx_q == '0);
      end
      PH_BODY: begin
        out_valid = in_valid;
        in_ready  = out_ready;
        out_data  = in_data;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_COLLECT;
      idx_q   <= '0;
      disc_q  <= 1'b0;
      corr_q  <= 1'b0;
      for (int i = 0; i < HDR_LEN; i++) hdr_q[i] <= 8'h00;
    end else begin
      unique case (phase_q)
        PH_COLLECT: if (in_valid) begin
          hdr_q[hdr_idx[HIDX_W-1:0]] <= in_data;
          if (verdict) begin
            for (int i = 0; i < HDR_LEN; i++) hdr_q[i] <= fixed[HDR_BITS-1-8*i -: 8];
            disc_q  <= mark_discard;
            corr_q  <= mark_corrected;
            phase_q <= PH_REPLAY;
            idx_q   <= '0;
          end else begin
            idx_q <= hdr_idx + 1'b1;
          end
        end
        PH_REPLAY: if (out_ready) begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(HDR_LEN - 1)) phase_q <= PH_BODY;
        end
        PH_BODY: if (in_valid && out_ready) begin
          if (idx_q == IDX_W'(CELL_LEN - 1)) begin
            phase_q <= PH_COLLECT;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: phase_q <= PH_COLLECT;
      endcase
    end
  end

  assign out_discard   = disc_q;
  assign out_corrected = corr_q;

  assign cnt_inc[0] = verdict && mark_corrected;
  assign cnt_inc[1] = verdict && mark_discard;

  for (genvar g = 0; g < 2; g++) begin : g_cnt
    atm_hec_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .count (cnt_val[g])
    );
  end

  assign cnt_corrected = cnt_val[0];
  assign cnt_discarded = cnt_val[1];

  assert_single_fix_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fix_mask));

  assert_flags_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sop) |-> $stable({out_discard, out_corrected}));

  assert_replay_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && phase_q == PH_REPLAY) |=> (out_valid && $stable(out_data)));

endmodule

// File: tb/atm_hec_guard_tb_top.sv
`timescale 1ns/1ps
module atm_hec_guard_tb_top;
  localparam int CW   = 3;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_corr_en = 1'b1;
  logic [1:0] cfg_thresh = 2'd0;
  logic cfg_err_ignore = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_data = 8'h00;
  logic in_sop = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_sop, out_discard, out_corrected;
  logic [CW-1:0] cnt_corrected, cnt_discarded;

  int n_tests = 0;
  int n_fail  = 0;
  int seed    = 0;
  int exp_nc  = 0;
  int exp_nd  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  atm_hec_guard #(.CELL_LEN(53), .CNT_W(CW)) dut_i (
    .clk, .rst_n, .cfg_corr_en, .cfg_thresh, .cfg_err_ignore,
    .in_valid, .in_ready, .in_data, .in_sop,
    .out_valid, .out_ready, .out_data, .out_sop, .out_discard, .out_corrected,
    .cnt_corrected, .cnt_discarded
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input logic [31:0] d);
    logic [7:0] r = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      if (r[7] ^ d[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [39:0] good_hdr(input int k);
    logic [31:0] h = 32'h0012_3450 + 32'(k * 97);
    return {h, ref_crc(h) ^ 8'h55};
  endfunction

  // Sends one cell and checks the output cell
  task automatic run_cell(input logic [39:0] sent, input logic [39:0] exp_hdr,
                          input bit e_disc, input bit e_corr, input bit stall, input string req);
    logic [7:0] tx [53];
    logic [7:0] rx [53];
    int ip = 0, op = 0, cyc = 0;
    bit held = 0, glitch = 0, early = 0, f_disc = 0, f_corr = 0, sop_ok = 0;
    bit xin, xout;
    seed++;
    for (int i = 0; i < 53; i++)
      tx[i] = (i < 5) ? sent[39-8*i -: 8] : 8'((seed * 13) + i);
    while (op < 53 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      out_ready = stall ? cyc[0] : 1'b1;
      if (!held) begin
        in_valid = (ip < 53) && (stall ? (cyc % 3 != 1) : 1'b1);
        in_data  = (ip < 53) ? tx[ip] : 8'h00;
        in_sop   = (ip == 0);
      end
      #1;
      xin  = in_valid && in_ready;
      xout = out_valid && out_ready;
      if (xout) begin
        rx[op] = out_data;
        if (op == 0) begin
          sop_ok = out_sop;
          f_disc = out_discard;
          f_corr = out_corrected;
          early  = (ip < 5);
        end else if (out_sop || out_discard != f_disc || out_corrected != f_corr) begin
          glitch = 1;
        end
        op++;
      end
      if (xin) ip++;
      held = in_valid && !xin;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    out_ready = 1'b1;
    check(op == 53, "R11", "output byte count", op, 53);
    check(sop_ok && !early, "R11", "sop on first byte after header", {early, sop_ok}, 2'b01);
    for (int i = 0; i < 5; i++)
      check(rx[i] == exp_hdr[39-8*i -: 8], req, $sformatf("header byte %0d", i), rx[i], exp_hdr[39-8*i -: 8]);
    begin
      bit pay_ok = 1;
      for (int i = 5; i < 53; i++) if (rx[i] !== tx[i]) pay_ok = 0;
      check(pay_ok, "R1", "payload pass-through", pay_ok, 1);
    end
    check(f_disc == e_disc, req, "discard flag", f_disc, e_disc);
    check(f_corr == e_corr, req, "corrected flag", f_corr, e_corr);
    check(!glitch, "R10", "flags stable over cell", glitch, 0);
    if (e_corr && exp_nc < CMAX) exp_nc++;
    if (e_disc && exp_nd < CMAX) exp_nd++;
    check(int'(cnt_corrected) == exp_nc, "R9", "corrected count", cnt_corrected, exp_nc);
    check(int'(cnt_discarded) == exp_nd, "R9", "discard count", cnt_discarded, exp_nd);
  endtask

  task automatic good(input bit stall, input string req);
    logic [39:0] h = good_hdr(seed);
    run_cell(h, h, 0, 0, stall, req);
  endtask

  task automatic t_reset;
    check(out_valid == 1'b0, "R2", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R2", "in_ready after reset", in_ready, 1);
    check(cnt_corrected == 0 && cnt_discarded == 0, "R2", "counters after reset",
          {cnt_corrected, cnt_discarded}, 0);
  endtask

  task automatic t_clean;
    good(0, "R1");
    good(1, "R1");
    good(1, "R11");
  endtask

  task automatic t_single_fix;
    int pos [3] = '{39, 2, 17};
    foreach (pos[k]) begin
      logic [39:0] h = good_hdr(seed + 100);
      run_cell(h ^ (40'd1 << pos[k]), h, 0, 1, k[0], "R3");
      good(0, "R7");
    end
  endtask

  task automatic t_multi;
    logic [39:0] h = good_hdr(seed + 200);
    logic [39:0] b = h ^ (40'd1 << 30) ^ (40'd1 << 5);
    run_cell(b, b, 1, 0, 0, "R4");
    b = h ^ (40'd1 << 10);
    run_cell(b, b, 1, 0, 1, "R5");
    good(0, "R7");
    run_cell(b, h, 0, 1, 0, "R7");
    good(0, "R7");
  endtask

  task automatic t_threshold(input logic [1:0] code, input int m);
    logic [39:0] h = good_hdr(seed + 300);
    logic [39:0] multi = h ^ 40'h00_0000_0300;
    logic [39:0] single = h ^ (40'd1 << 25);
    cfg_thresh = code;
    run_cell(multi, multi, 1, 0, 0, "R4");
    for (int i = 0; i < m; i++) good(0, "R7");
    run_cell(single, single, 1, 0, 0, "R7");
    for (int i = 0; i <= m; i++) good(0, "R5");
    run_cell(single, h, 0, 1, 0, "R7");
    cfg_thresh = 2'd0;
    good(0, "R7");
  endtask

  task automatic t_ignore;
    logic [39:0] h = good_hdr(seed + 400);
    logic [39:0] multi = h ^ 40'h01_0000_0001;
    logic [39:0] single = h ^ (40'd1 << 33);
    cfg_err_ignore = 1'b1;
    run_cell(multi, multi, 0, 0, 0, "R6");
    run_cell(single, single, 0, 0, 1, "R6");
    cfg_err_ignore = 1'b0;
    good(0, "R6");
  endtask

  task automatic t_disable;
    logic [39:0] h = good_hdr(seed + 500);
    logic [39:0] single = h ^ (40'd1 << 12);
    cfg_corr_en = 1'b0;
    good(0, "R8");
    good(0, "R8");
    run_cell(single, single, 1, 0, 0, "R8");
    good(0, "R8");
    good(0, "R8");
    run_cell(single, single, 1, 0, 0, "R8");
    cfg_corr_en = 1'b1;
    good(0, "R8");
    run_cell(single, h, 0, 1, 0, "R8");
    good(0, "R8");
  endtask

  task automatic t_resync;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_data  = 8'hA0 + 8'(i);
      #1;
      check(out_valid == 1'b0, "R12", "no output from partial header", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sop   = 1'b0;
    good(0, "R12");
  endtask

  task automatic t_saturate;
    logic [39:0] h = good_hdr(seed + 600);
    logic [39:0] multi = h ^ 40'h80_0000_0080;
    run_cell(multi, multi, 1, 0, 0, "R9");
    check(int'(cnt_discarded) == CMAX, "R9", "discard count saturated", cnt_discarded, CMAX);
    check(int'(cnt_corrected) == CMAX, "R9", "corrected count saturated", cnt_corrected, CMAX);
    good(0, "R9");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_single_fix();
    t_multi();
    t_threshold(2'd1, 1);
    t_threshold(2'd2, 3);
    t_threshold(2'd3, 7);
    t_ignore();
    t_disable();
    t_resync();
    t_saturate();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule